// File: doc/BRIEF.md
# Bidirectional Pin Boundary Scan Chain

This block is a boundary scan register that wraps a row of bidirectional pins. It sits between the core logic and the pad ring. In normal operation it passes signals straight through. Under a test instruction it can capture what the pins see, take a serial pattern from the test data input, and drive the pins from a held update stage instead of from the core.

Each pin owns two cells. The first is a control cell that decides whether the pin driver is on. The second is a data cell that holds the value to drive and captures the pad input. Every cell has a capture/shift flip-flop clocked on the rising test clock edge. It also has an update stage loaded on the falling edge while the update strobe is high. A separate TAP controller supplies the capture, shift and update strobes and a decoded 3-bit mode code. That controller and the pad electrical behaviour are outside this block.

A 1 in a control cell turns the pin driver off. The control update stages reset to 1, so every pin comes up disabled when a test instruction takes over.

Top module: `bscan_pin_chain`

## Requirements
- R1: While `trst_n` is low, every control cell's update and shift stages hold 1 and every data cell's stages hold 0. Under mode 2, right after reset, all `pad_oe` bits are therefore 0 and all `pad_out` bits are 0.
- R2: For mode 0 (functional) and for the unused codes 5, 6 and 7, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`.
- R3: `core_in` equals `pad_in` in every mode.
- R4: Cell order on the chain:
  - Cell 2k is the control cell of pin k, and cell 2k+1 is the data cell of pin k.
  - `tdi` enters cell 2N-1, and `tdo` shows cell 0.
  - With mode 1 or 2 and `shift_dr` high, each rising `tck` moves every cell one place toward `tdo`.
- R5: With mode 1 or 2 and `capture_dr` high at a rising edge:
  - control cell k loads NOT `core_oe[k]`;
  - data cell k loads `pad_in[k]`, whether or not its driver is enabled.
- R6: Mode 1 (sample/preload) leaves the pads transparent as in R2, while shifting and update still work on the chain.
- R7: The update stage loads the shift stage on a falling `tck` edge only while `update_dr` is high in mode 1 or 2. Shifting without an update leaves the pads unchanged.
- R8: Mode 2 (external test):
  - `pad_out[k]` is the data cell's update value;
  - `pad_oe[k]` is the inverse of the control cell's update value, so a control value of 1 leaves pin k undriven.
- R9: Mode 3 (clamp) drives the pads from the update stage as in R8. The chain neither captures, shifts nor updates, so `tdo` and the pads hold still under strobes.
- R10: Mode 4 (high impedance) forces every `pad_oe` bit to 0, and the chain neither captures, shifts nor updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| mode | input | 3 | Decoded instruction: 0 func, 1 sample/preload, 2 external test, 3 clamp, 4 high-z |
| capture_dr | input | 1 | Capture strobe, sampled on rising tck |
| shift_dr | input | 1 | Shift strobe, sampled on rising tck |
| update_dr | input | 1 | Update strobe, acted on at falling tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (cell 0) |
| core_out | input | NUM_PINS | Core output data per pin |
| core_oe | input | NUM_PINS | Core output enable per pin |
| core_in | output | NUM_PINS | Pad input returned to the core |
| pad_out | output | NUM_PINS | Data to pad driver |
| pad_oe | output | NUM_PINS | Pad driver enable |
| pad_in | input | NUM_PINS | Value seen at the pad |

## Verification
The hardest case to reach is proving that the update stage does not move. Examples are a full shift with no update strobe, or a full scan with strobes under clamp. The update stage is only visible through the pads in modes 2 and 3. The bench therefore preloads a known pattern, runs the disturbing scan, and then switches to external test to read the update stage back at the pads. Randomly chosen enables and pad values check that data cells capture the pad even when their driver is off.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
   typedef enum logic [2:0] {
      BSM_FUNC   = 3'd0,
      BSM_SAMPLE = 3'd1,
      BSM_EXTEST = 3'd2,
      BSM_CLAMP  = 3'd3,
      BSM_HIGHZ  = 3'd4
   } bsm_mode_e;

   // Safe (reset) values per cell kind.
   localparam logic CTRL_SAFE = 1'b1;
   localparam logic DATA_SAFE = 1'b0;

   function automatic logic mode_scans(input logic [2:0] m);
      return (m == BSM_SAMPLE) || (m == BSM_EXTEST);
   endfunction
endpackage

// File: rtl/bscan_mode_dec.sv
module bscan_mode_dec
   import bscan_pkg::*;
(
   input  logic [2:0] mode,
   input  logic       capture_dr,
   input  logic       shift_dr,
   input  logic       update_dr,
   output logic       cap_en,
   output logic       shf_en,
   output logic       upd_en,
   output logic       pins_from_upd,
   output logic       pins_off
);
   logic scan_sel;

   always_comb begin
      scan_sel      = mode_scans(mode);
      pins_from_upd = (mode == BSM_EXTEST) || (mode == BSM_CLAMP);
      pins_off      = (mode == BSM_HIGHZ);
      cap_en        = scan_sel & capture_dr;
      shf_en        = scan_sel & shift_dr & ~capture_dr;
      upd_en        = scan_sel & update_dr;
   end
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell #(
   parameter logic RST_VAL     = 1'b0,
   parameter bit   UPD_NEGEDGE = 1'b1
) (
   input  logic tck,
   input  logic trst_n,
   input  logic cap_en,
   input  logic shf_en,
   input  logic upd_en,
   input  logic cap_d,
   input  logic si,
   output logic sq,
   output logic uq
);
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)     sq <= RST_VAL;
      else if (cap_en) sq <= cap_d;
      else if (shf_en) sq <= si;
   end

   generate
      if (UPD_NEGEDGE) begin : g_upd_fall
         always_ff @(negedge tck or negedge trst_n) begin
            if (!trst_n)     uq <= RST_VAL;
            else if (upd_en) uq <= sq;
         end
      end else begin : g_upd_rise
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)     uq <= RST_VAL;
            else if (upd_en) uq <= sq;
         end
      end
   endgenerate
endmodule

// File: rtl/bscan_pin_pair.sv
module bscan_pin_pair
   import bscan_pkg::*;
#(
   parameter bit UPD_NEGEDGE = 1'b1
) (
   input  logic tck,
   input  logic trst_n,
   input  logic cap_en,
   input  logic shf_en,
   input  logic upd_en,
   input  logic pins_from_upd,
   input  logic pins_off,
   input  logic si,
   output logic so,
   input  logic core_out,
   input  logic core_oe,
   output logic core_in,
   output logic pad_out,
   output logic pad_oe,
   input  logic pad_in
);
   logic data_sq, data_uq, ctrl_sq, ctrl_uq;

   // Data cell (odd index) sits nearer tdi than its control cell.
   bscan_cell #(.RST_VAL(DATA_SAFE), .UPD_NEGEDGE(UPD_NEGEDGE)) data_cell_i (
      .tck(tck), .trst_n(trst_n), .cap_en(cap_en), .shf_en(shf_en),
      .upd_en(upd_en), .cap_d(pad_in), .si(si), .sq(data_sq), .uq(data_uq)
   );

   // Control cell (even index): 1 means driver off.
   bscan_cell #(.RST_VAL(CTRL_SAFE), .UPD_NEGEDGE(UPD_NEGEDGE)) ctrl_cell_i (
      .tck(tck), .trst_n(trst_n), .cap_en(cap_en), .shf_en(shf_en),
      .upd_en(upd_en), .cap_d(~core_oe), .si(data_sq), .sq(ctrl_sq), .uq(ctrl_uq)
   );

   assign so = ctrl_sq;

   always_comb begin
      core_in = pad_in;
      if (pins_off) begin
         pad_out = data_uq;
         pad_oe  = 1'b0;
      end else if (pins_from_upd) begin
         pad_out = data_uq;
         pad_oe  = ~ctrl_uq;
      end else begin
         pad_out = core_out;
         pad_oe  = core_oe;
      end
   end
endmodule

// File: rtl/bscan_pin_chain.sv
module bscan_pin_chain
   import bscan_pkg::*;
#(
   parameter int NUM_PINS    = 98,
   parameter bit UPD_NEGEDGE = 1'b1
) (
   input  logic                tck,
   input  logic                trst_n,
   input  logic [2:0]          mode,
   input  logic                capture_dr,
   input  logic                shift_dr,
   input  logic                update_dr,
   input  logic                tdi,
   output logic                tdo,
   input  logic [NUM_PINS-1:0] core_out,
   input  logic [NUM_PINS-1:0] core_oe,
   output logic [NUM_PINS-1:0] core_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   input  logic [NUM_PINS-1:0] pad_in
);
   localparam int NUM_CELLS = 2 * NUM_PINS;

   generate
      if (NUM_PINS < 1) begin : g_bad_pins
         $error("bscan_pin_chain: NUM_PINS must be at least 1");
      end
      if (NUM_CELLS > 4096) begin : g_bad_len
         $error("bscan_pin_chain: chain longer than supported");
      end
   endgenerate

   logic cap_en, shf_en, upd_en, pins_from_upd, pins_off;
   logic [NUM_PINS:0] link;

   bscan_mode_dec dec_i (
      .mode(mode), .capture_dr(capture_dr), .shift_dr(shift_dr),
      .update_dr(update_dr), .cap_en(cap_en), .shf_en(shf_en),
      .upd_en(upd_en), .pins_from_upd(pins_from_upd), .pins_off(pins_off)
   );

   assign link[NUM_PINS] = tdi;
   assign tdo            = link[0];

   generate
      for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
         bscan_pin_pair #(.UPD_NEGEDGE(UPD_NEGEDGE)) pair_i (
            .tck(tck), .trst_n(trst_n), .cap_en(cap_en), .shf_en(shf_en),
            .upd_en(upd_en), .pins_from_upd(pins_from_upd), .pins_off(pins_off),
            .si(link[k+1]), .so(link[k]),
            .core_out(core_out[k]), .core_oe(core_oe[k]), .core_in(core_in[k]),
            .pad_out(pad_out[k]), .pad_oe(pad_oe[k]), .pad_in(pad_in[k])
         );
      end
   endgenerate
endmodule

// File: rtl/bscan_pin_chain_chk.sv
module bscan_pin_chain_chk
   import bscan_pkg::*;
#(
   parameter int NUM_PINS = 98
) (
   input logic                tck,
   input logic                trst_n,
   input logic [2:0]          mode,
   input logic                capture_dr,
   input logic                shift_dr,
   input logic                update_dr,
   input logic                tdi,
   input logic                tdo,
   input logic [NUM_PINS-1:0] core_out,
   input logic [NUM_PINS-1:0] core_oe,
   input logic [NUM_PINS-1:0] core_in,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] pad_in
);
   // R2
   func_transparent_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == BSM_FUNC) |-> (pad_out == core_out && pad_oe == core_oe));

   // R3
   core_in_follows_pad_chk: assert property (@(posedge tck) disable iff (!trst_n)
      core_in == pad_in);

   // R10
   highz_all_off_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == BSM_HIGHZ) |-> (pad_oe == '0));

   // R7
   extest_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == BSM_EXTEST && $past(mode) == BSM_EXTEST && !update_dr)
      |-> ($stable(pad_out) && $stable(pad_oe)));

   // R9
   clamp_frozen_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == BSM_CLAMP && $past(mode) == BSM_CLAMP)
      |-> ($stable(pad_out) && $stable(pad_oe) && $stable(tdo)));
endmodule

bind bscan_pin_chain bscan_pin_chain_chk #(.NUM_PINS(NUM_PINS)) chk_i (.*);

// File: tb/bscan_pin_chain_tb_top.sv
module bscan_pin_chain_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 8;
   localparam int NC = 2 * NP;

   logic          tck = 1'b0;
   logic          trst_n;
   logic [2:0]    mode;
   logic          capture_dr, shift_dr, update_dr, tdi, tdo;
   logic [NP-1:0] core_out, core_oe, core_in, pad_out, pad_oe, pad_in;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   bscan_pin_chain #(.NUM_PINS(NP)) dut_i (
      .tck(tck), .trst_n(trst_n), .mode(mode), .capture_dr(capture_dr),
      .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
      .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
   );

   always #(CLK_PERIOD/2) tck = ~tck;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge tck); #1;
   endtask

   task automatic settle();
      @(negedge tck); #1;
   endtask

   // Expected captured chain: even cell = ~oe, odd cell = pad_in.
   function automatic logic [NC-1:0] exp_cap(input logic [NP-1:0] oe,
                                             input logic [NP-1:0] pin);
      logic [NC-1:0] v;
      for (int k = 0; k < NP; k++) begin
         v[2*k]   = ~oe[k];
         v[2*k+1] = pin[k];
      end
      return v;
   endfunction

   function automatic logic [NP-1:0] exp_out(input logic [NC-1:0] v);
      logic [NP-1:0] r;
      for (int k = 0; k < NP; k++) r[k] = v[2*k+1];
      return r;
   endfunction

   function automatic logic [NP-1:0] exp_oe(input logic [NC-1:0] v);
      logic [NP-1:0] r;
      for (int k = 0; k < NP; k++) r[k] = ~v[2*k];
      return r;
   endfunction

   // din[j] ends up in cell j; dout[j] is cell j as it stood before shifting.
   task automatic scan(input logic [NC-1:0] din, output logic [NC-1:0] dout,
                       input bit do_cap, input bit do_upd);
      step();
      if (do_cap) begin
         capture_dr = 1'b1;
         step();
         capture_dr = 1'b0;
      end
      shift_dr = 1'b1;
      for (int j = 0; j < NC; j++) begin
         settle();
         dout[j] = tdo;
         tdi = din[j];
         @(posedge tck); #1;
      end
      shift_dr = 1'b0;
      if (do_upd) begin
         update_dr = 1'b1;
         step();
         update_dr = 1'b0;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [NC-1:0] pre, got, nxt;
      logic [NP-1:0] oe_r, pin_r;
      void'($urandom(32'h5eed_0b5c));
      trst_n = 1'b0; mode = 3'd0; capture_dr = 0; shift_dr = 0; update_dr = 0;
      tdi = 0; core_out = '0; core_oe = '0; pad_in = '0;
      repeat (3) step();
      trst_n = 1'b1;

      // R1: reset state seen through external test
      mode = 3'd2;
      settle();
      chk(pad_oe == '0, "R1 oe", pad_oe, 0);
      chk(pad_out == '0, "R1 out", pad_out, 0);

      // R2, R3: functional path and unused codes
      for (int i = 0; i < 24; i++) begin
         step();
         mode = (i < 16) ? 3'd0 : 3'(5 + (i % 3));
         core_out = NP'($urandom); core_oe = NP'($urandom); pad_in = NP'($urandom);
         settle();
         chk(pad_out == core_out && pad_oe == core_oe, "R2 transparent",
             {pad_out, pad_oe}, {core_out, core_oe});
         chk(core_in == pad_in, "R3 core_in", core_in, pad_in);
      end

      // R4, R5, R6: sample/preload with random and directed patterns
      for (int i = 0; i < 6; i++) begin
         step();
         mode = 3'd1;
         oe_r  = (i == 0) ? '1 : (i == 1) ? '0 : NP'($urandom);
         pin_r = (i == 0) ? '1 : (i == 1) ? '0 : NP'($urandom);
         core_oe = oe_r; pad_in = pin_r; core_out = NP'($urandom);
         pre = NC'($urandom);
         scan(pre, got, 1'b1, 1'b1);
         chk(got == exp_cap(oe_r, pin_r), "R5 capture/R4 order", got, exp_cap(oe_r, pin_r));
         settle();
         chk(pad_out == core_out && pad_oe == core_oe, "R6 sample transparent",
             {pad_out, pad_oe}, {core_out, core_oe});
         // R8: preloaded values appear under external test
         step();
         mode = 3'd2;
         settle();
         chk(pad_out == exp_out(pre) && pad_oe == exp_oe(pre), "R8 extest drive",
             {pad_out, pad_oe}, {exp_out(pre), exp_oe(pre)});
      end

      // R4: shifting moves pattern through whole chain to tdo
      step();
      mode = 3'd1;
      pre = 16'hA5C3;
      scan(pre, got, 1'b0, 1'b0);
      nxt = 16'h0F69;
      scan(nxt, got, 1'b0, 1'b0);
      chk(got == pre, "R4 chain order", got, pre);

      // R7: shift without update leaves pads
      step();
      mode = 3'd2;
      pre = 16'h6C39;
      scan(pre, got, 1'b0, 1'b1);
      nxt = ~pre;
      scan(nxt, got, 1'b0, 1'b0);
      settle();
      chk(pad_out == exp_out(pre) && pad_oe == exp_oe(pre), "R7 no update hold",
          {pad_out, pad_oe}, {exp_out(pre), exp_oe(pre)});
      step();
      update_dr = 1'b1; step(); update_dr = 1'b0;
      settle();
      chk(pad_out == exp_out(nxt) && pad_oe == exp_oe(nxt), "R7 update loads",
          {pad_out, pad_oe}, {exp_out(nxt), exp_oe(nxt)});

      // R9: clamp drives update stage and ignores strobes
      step();
      mode = 3'd3;
      settle();
      chk(pad_out == exp_out(nxt) && pad_oe == exp_oe(nxt), "R9 clamp drive",
          {pad_out, pad_oe}, {exp_out(nxt), exp_oe(nxt)});
      scan(pre, got, 1'b1, 1'b1);
      settle();
      chk(pad_out == exp_out(nxt) && pad_oe == exp_oe(nxt), "R9 clamp frozen",
          {pad_out, pad_oe}, {exp_out(nxt), exp_oe(nxt)});
      step();
      mode = 3'd2;
      settle();
      chk(pad_out == exp_out(nxt), "R9 update untouched", pad_out, exp_out(nxt));

      // R10: high-z forces every driver off and freezes chain
      step();
      mode = 3'd4;
      core_oe = '1;
      settle();
      chk(pad_oe == '0, "R10 highz", pad_oe, 0);
      scan(pre, got, 1'b1, 1'b1);
      step();
      mode = 3'd2;
      settle();
      chk(pad_out == exp_out(nxt) && pad_oe == exp_oe(nxt), "R10 chain frozen",
          {pad_out, pad_oe}, {exp_out(nxt), exp_oe(nxt)});

      // R1: reset in the middle of external test restores safe values
      trst_n = 1'b0;
      settle();
      chk(pad_oe == '0 && pad_out == '0, "R1 midrun reset", {pad_out, pad_oe}, 0);
      step();
      trst_n = 1'b1;

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule